// File: doc/BRIEF.md
# Serial Flash Protection-Register Read Responder

This block sits on the peripheral side of a four-wire serial flash link. It watches the active-low chip select, the serial clock and the serial data input. It answers one command: a read of a four-byte sector protection register. The controller sends the command byte and then three filler bytes. After that, each further clock pulse shifts one bit of the register out on the serial data output. The four register bytes come in on a parallel port from the surrounding logic. The block never programs or stores them. It takes a copy of them at the moment the filler phase ends.

The serial pins are not used as clocks. They are sampled by the system clock through a synchronizer and then edge-detected. The link runs in mode 0, so the input is captured on the rising edge of the serial clock and the output changes on the falling edge. Bits travel most significant first. The output driver is controlled by a separate enable signal, which the pad logic turns into the high-impedance state. That enable depends combinationally on the raw chip-select pin, so releasing chip select turns the driver off at once.

Both phases of the serial clock must last at least SYNC_STAGES+2 system clock cycles. Chip select must stay high for at least four system clock cycles between transactions.

Top module: `spi_prot_reader`

## Requirements
- R1: While `cs_n` is high, edges on `sck` and values on `si` are ignored. Each new low level of `cs_n` restarts bit and byte counting from zero, so a transaction that was cut short has no effect on the next one.
- R2: The first byte after chip select is captured from `si` on rising `sck` edges, most significant bit first, and compared with the command value 0x32.
- R3: The three bytes that follow the command are fillers. Their values have no effect on the data returned.
- R4: Output begins at the 32nd falling edge of `sck`, which drives data bit 7 of the first byte, so the bit is valid before the 33rd rising edge. `so_d` changes only after falling edges, with bits sent most significant first.
- R5: The response bytes come out in sector order 0, 1, 2, 3. Sector k is taken from `prot_in[8k+7:8k]`.
- R6: After the fourth response byte, `so_oe` stays high for as long as clocks continue, and `so_d` drives all ones.
- R7: When `cs_n` goes high, `so_oe` drops in the same instant, with no clock edge needed.
- R8: If the command byte is not 0x32, `so_oe` stays low until `cs_n` is released.
- R9: `prot_in` is copied at the last rising edge of the filler phase. Changes on `prot_in` after that point do not alter the bytes being sent.
- R10: `so_oe` is low after reset and during the command and filler phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the controller, idle low |
| si | input | 1 | Serial data from the controller |
| prot_in | input | 32 | Protection bytes; sector k is at bits [8k+7:8k] |
| so_d | output | 1 | Serial data output value |
| so_oe | output | 1 | Output driver enable; when low the pad is high impedance |

## Verification
If the internal bit or byte count is off by even one, the whole response shifts. The controller then sees a wrong first bit on the very first data byte, or sees the driver turn on inside the filler phase. A wrong command-match flag shows at the ports within one byte: either the driver is enabled after a bad command, or it stays off after a good one. The bench sweeps a single set bit across all 32 register positions, every command value other than the correct one, and different filler values. This way each misplaced bit, byte swap or missing capture shows up as a mismatched byte.

// File: rtl/spr_pkg.sv
package spr_pkg;

  // next byte index, saturating at the tail index
  function automatic int next_byte_idx(input int cur, input int last);
    return (cur >= last) ? last : cur + 1;
  endfunction

  // response position of a byte index (negative before the data phase)
  function automatic int resp_slot(input int byte_idx, input int data_start);
    return byte_idx - data_start;
  endfunction

  // bit offset inside a byte for the nth bit sent, MSB first
  function automatic int msb_first_pos(input int nth, input int byte_w);
    return byte_w - 1 - nth;
  endfunction

endpackage

// File: rtl/spr_sync.sv
module spr_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spr_frame.sv
module spr_frame #(
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] OPCODE = 8'h32,
  parameter int BIT_W = 3,
  parameter int CNT_W = 4,
  parameter int DATA_START = 4,
  parameter int LAST_IDX = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_s,
  input  logic             sck_s,
  input  logic             si_s,
  output logic             cs_idle,
  output logic             sck_rise,
  output logic             sck_fall,
  output logic [BIT_W-1:0] bit_cnt,
  output logic [CNT_W-1:0] byte_cnt,
  output logic             cmd_ok,
  output logic             cmd_bad,
  output logic             dummy_end
);
  import spr_pkg::*;

  logic              sck_q;
  logic [BYTE_W-1:0] rx_sr;
  logic [BYTE_W-1:0] rx_next;
  logic              bit_last;
  logic              byte_done;

  assign cs_idle   = cs_s;
  assign sck_rise  = !cs_s && sck_s && !sck_q;
  assign sck_fall  = !cs_s && !sck_s && sck_q;
  assign rx_next   = {rx_sr[BYTE_W-2:0], si_s};
  assign bit_last  = (int'(bit_cnt) == BYTE_W - 1);
  assign byte_done = sck_rise && bit_last;
  assign dummy_end = byte_done && cmd_ok && (int'(byte_cnt) == DATA_START - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck_s;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || cs_s) begin
      bit_cnt  <= '0;
      byte_cnt <= '0;
      rx_sr    <= '0;
      cmd_ok   <= 1'b0;
      cmd_bad  <= 1'b0;
    end else if (sck_rise) begin
      rx_sr   <= rx_next;
      bit_cnt <= bit_last ? '0 : bit_cnt + 1'b1;
      if (bit_last) begin
        byte_cnt <= CNT_W'(next_byte_idx(int'(byte_cnt), LAST_IDX));
        if (byte_cnt == '0) begin
          cmd_ok  <= (rx_next == OPCODE);
          cmd_bad <= (rx_next != OPCODE);
        end
      end
    end
  end
endmodule

// File: rtl/spr_tx.sv
module spr_tx #(
  parameter int BYTE_W = 8,
  parameter int N_SECT = 4,
  parameter int BIT_W = 3,
  parameter int CNT_W = 4,
  parameter int DATA_START = 4,
  localparam int TOT_W = BYTE_W * N_SECT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_idle,
  input  logic             sck_fall,
  input  logic             cmd_ok,
  input  logic             dummy_end,
  input  logic [BIT_W-1:0] bit_cnt,
  input  logic [CNT_W-1:0] byte_cnt,
  input  logic [TOT_W-1:0] prot_in,
  output logic [TOT_W-1:0] snap,
  output logic             so_d,
  output logic             tx_active
);
  import spr_pkg::*;

  function automatic logic resp_bit(input logic [TOT_W-1:0] s,
                                    input int slot, input int nth);
    if (slot < 0 || slot >= N_SECT) return 1'b1;
    return s[slot * BYTE_W + msb_first_pos(nth, BYTE_W)];
  endfunction

  logic in_data;
  assign in_data = cmd_ok && (int'(byte_cnt) >= DATA_START);

  always_ff @(posedge clk) begin
    if (!rst_n)         snap <= '0;
    else if (dummy_end) snap <= prot_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      so_d      <= 1'b1;
      tx_active <= 1'b0;
    end else if (cs_idle) begin
      tx_active <= 1'b0;
    end else if (sck_fall && in_data) begin
      tx_active <= 1'b1;
      so_d      <= resp_bit(snap, resp_slot(int'(byte_cnt), DATA_START),
                            int'(bit_cnt));
    end
  end
endmodule

// File: rtl/spi_prot_reader.sv
module spi_prot_reader #(
  parameter int BYTE_W = 8,
  parameter int N_SECT = 4,
  parameter int N_DUMMY = 3,
  parameter int SYNC_STAGES = 2,
  parameter logic [BYTE_W-1:0] OPCODE = 8'h32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cs_n,
  input  logic                     sck,
  input  logic                     si,
  input  logic [BYTE_W*N_SECT-1:0] prot_in,
  output logic                     so_d,
  output logic                     so_oe
);
  localparam int TOT_W      = BYTE_W * N_SECT;
  localparam int BIT_W      = $clog2(BYTE_W);
  localparam int DATA_START = 1 + N_DUMMY;
  localparam int LAST_IDX   = DATA_START + N_SECT;
  localparam int CNT_W      = $clog2(LAST_IDX + 1);

  logic [2:0]       pins_s;
  logic             cs_idle, sck_rise, sck_fall;
  logic [BIT_W-1:0] bit_cnt;
  logic [CNT_W-1:0] byte_cnt;
  logic             cmd_ok, cmd_bad, dummy_end;
  logic [TOT_W-1:0] snap;
  logic             tx_active;

  spr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sck, si}), .q(pins_s)
  );

  spr_frame #(
    .BYTE_W(BYTE_W), .OPCODE(OPCODE), .BIT_W(BIT_W), .CNT_W(CNT_W),
    .DATA_START(DATA_START), .LAST_IDX(LAST_IDX)
  ) u_frame (
    .clk(clk), .rst_n(rst_n),
    .cs_s(pins_s[2]), .sck_s(pins_s[1]), .si_s(pins_s[0]),
    .cs_idle(cs_idle), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .bit_cnt(bit_cnt), .byte_cnt(byte_cnt),
    .cmd_ok(cmd_ok), .cmd_bad(cmd_bad), .dummy_end(dummy_end)
  );

  spr_tx #(
    .BYTE_W(BYTE_W), .N_SECT(N_SECT), .BIT_W(BIT_W), .CNT_W(CNT_W),
    .DATA_START(DATA_START)
  ) u_tx (
    .clk(clk), .rst_n(rst_n), .cs_idle(cs_idle), .sck_fall(sck_fall),
    .cmd_ok(cmd_ok), .dummy_end(dummy_end), .bit_cnt(bit_cnt),
    .byte_cnt(byte_cnt), .prot_in(prot_in), .snap(snap),
    .so_d(so_d), .tx_active(tx_active)
  );

  // raw pin gates the driver so release takes effect without a clock
  assign so_oe = !cs_n && tx_active;
endmodule

// File: rtl/spr_checker.sv
module spr_checker #(
  parameter int BIT_W = 3,
  parameter int CNT_W = 4,
  parameter int TOT_W = 32,
  parameter int DATA_START = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             so_oe,
  input logic             so_d,
  input logic             cs_idle,
  input logic             sck_rise,
  input logic             sck_fall,
  input logic [BIT_W-1:0] bit_cnt,
  input logic [CNT_W-1:0] byte_cnt,
  input logic             cmd_ok,
  input logic             cmd_bad,
  input logic [TOT_W-1:0] snap
);
  assert_bad_cmd_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_bad |-> !so_oe);

  assert_so_fall_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_fall |=> $stable(so_d));

  assert_snap_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(byte_cnt) >= DATA_START) |=> $stable(snap));

  assert_oe_late_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(so_oe) |-> (cmd_ok && int'(byte_cnt) >= DATA_START));

  assert_cnt_rise_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!sck_rise && !cs_idle) |=> $stable(bit_cnt));

  assert_cmd_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_ok && cmd_bad));
endmodule

bind spi_prot_reader spr_checker #(
  .BIT_W(BIT_W), .CNT_W(CNT_W), .TOT_W(TOT_W), .DATA_START(DATA_START)
) u_chk (
  .clk(clk), .rst_n(rst_n), .so_oe(so_oe), .so_d(so_d), .cs_idle(cs_idle),
  .sck_rise(sck_rise), .sck_fall(sck_fall), .bit_cnt(bit_cnt),
  .byte_cnt(byte_cnt), .cmd_ok(cmd_ok), .cmd_bad(cmd_bad), .snap(snap)
);

// File: tb/tb_spi_prot_reader.sv
module tb_spi_prot_reader;
  localparam int LOW_CLK  = 6;
  localparam int HIGH_CLK = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sck = 1'b0;
  logic        si = 1'b0;
  logic [31:0] prot_in = '0;
  logic        so_d, so_oe;

  int n_chk = 0;
  int n_bad = 0;
  int edge_err = 0;
  int cyc = 0;
  bit done = 0;

  spi_prot_reader dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .prot_in(prot_in), .so_d(so_d), .so_oe(so_oe)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000 && !done) begin
      n_chk = n_chk + 1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run did not finish, act=%0d cycles exp<190000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one mode-0 bit: sample SO before the rise, check it holds until the fall
  task automatic spi_bit(input logic mosi, output logic miso, output logic oe);
    @(negedge clk);
    si = mosi;
    repeat (LOW_CLK - 1) @(negedge clk);
    miso = so_d;
    oe = so_oe;
    sck = 1'b1;
    repeat (HIGH_CLK - 1) @(negedge clk);
    if (oe && so_oe && so_d !== miso) edge_err++;
    @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic spi_byte(input logic [7:0] mosi, output logic [7:0] miso,
                          output bit oe_any, output bit oe_all);
    logic b, o;
    oe_any = 0;
    oe_all = 1;
    for (int i = 7; i >= 0; i--) begin
      spi_bit(mosi[i], b, o);
      miso[i] = b;
      if (o) oe_any = 1; else oe_all = 0;
    end
  endtask

  task automatic cs_on();
    @(negedge clk);
    cs_n = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic cs_off();
    @(negedge clk);
    cs_n = 1'b1;
    #1;
    chk(so_oe == 1'b0, "R7 so_oe off at release", {31'd0, so_oe}, 32'd0);
    repeat (10) @(negedge clk);
  endtask

  // full transaction; swap prot_in after the filler phase when requested
  task automatic run_read(input logic [31:0] prot, input logic [7:0] op,
                          input logic [23:0] fill, input bit swap,
                          input int tail);
    logic [7:0] rx;
    bit any, all, pre_any;
    prot_in = prot;
    cs_on();
    spi_byte(op, rx, any, all);
    pre_any = any;
    for (int k = 2; k >= 0; k--) begin
      spi_byte(fill[k*8 +: 8], rx, any, all);
      pre_any = pre_any | any;
    end
    chk(!pre_any, "R10 so_oe low in command/filler", {31'd0, pre_any}, 32'd0);
    if (op == 8'h32) begin
      if (swap) prot_in = ~prot;
      for (int k = 0; k < 4; k++) begin
        spi_byte(8'h00, rx, any, all);
        chk(rx == prot[k*8 +: 8],
            swap ? "R9 held copy byte" : "R5 sector byte", {24'd0, rx},
            {24'd0, prot[k*8 +: 8]});
        chk(all, "R4 so_oe high in data byte", {31'd0, all}, 32'd1);
      end
      for (int t = 0; t < tail; t++) begin
        spi_byte(8'h00, rx, any, all);
        chk(all, "R6 so_oe held after last byte", {31'd0, all}, 32'd1);
      end
    end else begin
      spi_byte(8'h00, rx, any, all);
      chk(!any, "R8 silent after bad command", {24'd0, op}, 32'h32);
    end
    cs_off();
  endtask

  initial begin
    logic b, o;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(so_oe == 1'b0, "R10 so_oe after reset", {31'd0, so_oe}, 32'd0);

    // R1: clocks while deselected are ignored
    for (int i = 0; i < 20; i++) spi_bit(i[0], b, o);
    chk(o == 1'b0, "R1 no drive while deselected", {31'd0, o}, 32'd0);
    run_read(32'h1E2D_3C4B, 8'h32, 24'hA5_5A_C3, 0, 1);

    // R2 R3 R4 R5: walking one over every register bit, fillers varied
    for (int j = 0; j < 32; j++)
      run_read(32'd1 << j, 8'h32, {j[7:0], ~j[7:0], 8'h32}, 0, 0);
    run_read(32'hFFFF_FFFF, 8'h32, 24'h00_00_00, 0, 0);
    run_read(32'h0000_0000, 8'h32, 24'hFF_FF_FF, 0, 0);

    // R9: input changes after capture do not disturb the readout
    run_read(32'h8421_7E96, 8'h32, 24'h12_34_56, 1, 0);
    run_read(32'h0F0F_F0F0, 8'h32, 24'h32_32_32, 1, 0);

    // R1: abort mid-command, then a clean transaction must still work
    cs_on();
    for (int i = 0; i < 13; i++) spi_bit(1'b1, b, o);
    cs_off();
    run_read(32'hCAFE_0B1D, 8'h32, 24'h99_88_77, 0, 0);

    // R8: every other command value leaves the driver off
    for (int op = 0; op < 256; op++)
      if (op != 8'h32) run_read(32'hDEAD_BEEF, op[7:0], 24'h11_22_33, 0, 0);
    run_read(32'h5A5A_A5A5, 8'h32, 24'h00_00_00, 0, 2);

    chk(edge_err == 0, "R4 so_d stable across high phase", edge_err, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule